// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel whose work list sits in memory as a chain of descriptors. Software first writes the address of the head descriptor and then sets the start bit. The channel then runs without further help. For each link it reads six 32-bit words through its memory port and loads them into its live registers. It copies the stated number of bytes from the source address to the destination address, one beat at a time, and then jumps to the link named in the descriptor. The walk ends after the descriptor whose next-link word equals the end marker 0xFFFFF800. At that point the channel returns to idle and raises a one-cycle completion pulse.

Each descriptor carries its own configuration word, so every link can choose its own widths, address modes, burst length and request ports. Request port 1 stands for plain memory, which is always ready. Any other port number makes the channel wait on that port's ready input before each burst. Software can freeze a running chain and release it without losing progress. It can also kill the chain outright. While the chain runs, software can watch the current source, destination, remaining byte count, configuration and parameter words.

Top module: `lli_dma_channel`

## Requirements
- R1: After reset every register reads zero, no memory access is requested and the completion output is low.
- R2: A descriptor is six words at consecutive word addresses, fetched in this order: configuration, source, destination, byte count, parameter, next link. After a chain ends, the configuration register (offset 0x0C) and the parameter register (offset 0x1C) hold the words of the last descriptor.
- R3: In linear mode (mode bit 0), an address advances after each beat by that beat's byte count. The source mode bit is configuration bit 5 and the destination mode bit is bit 21.
- R4: In fixed mode (mode bit 1), an address never changes during a descriptor.
- R5: The width codes sit in configuration bits 10:9 (source) and 26:25 (destination). Code 0 means 1 byte, code 1 means 2 bytes and code 2 means 4 bytes. A beat uses the narrower of the two widths, and mem_size carries the beat's code.
- R6: When fewer bytes remain than the beat width, the rest of the descriptor moves in single-byte beats.
- R7: The chain follows next links until a next-link word equals 0xFFFFF800. The channel then goes idle, so the enable register (offset 0x00, bit 0) reads 0, and queue_done pulses high for exactly one cycle.
- R8: A descriptor with a byte count of zero moves no data, and the channel fetches the following link directly.
- R9: The request ports sit in configuration bits 4:0 (source) and 20:16 (destination), and port value 1 means memory. For any other port, each burst waits until port_rdy at that port index is high. The burst codes sit in bits 8:7 and 24:23. If either code is 2, a burst is 8 beats; otherwise a burst is 1 beat.
- R10: The remaining-count register (offset 0x18) gives the bytes still to move in the active descriptor. The source register (0x10) and destination register (0x14) give the live addresses.
- R11: Writing a value with bit 1 set to the pause register (offset 0x04) stops all new memory accesses, and the count and addresses do not change. Writing bit 1 clear lets the transfer carry on where it stopped. The pause register reads back bit 1.
- R12: Writing 0 to bit 0 of the enable register stops the channel at once, with no completion pulse. A write to the descriptor address register (offset 0x08) takes effect only while the channel is idle.
- R13: Once a memory access is requested, its address, size and write flag stay constant until mem_gnt, unless the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, right-aligned, valid with mem_gnt |
| port_rdy | input | 32 | Per-port peripheral ready |
| queue_done | output | 1 | One-cycle pulse when the chain ends |

## Verification
Most internal faults in this channel show up quickly as a write with the wrong address, size or data. The next destination write after the fault reaches the scoreboard, which checks each write against a beat list built from the descriptor contents. A wrong fetch index or a broken next-link decision shows up differently: the write stream stops early, or the completion pulse comes twice or not at all, and the bench catches this within its per-chain time limit. Faults in pause and request gating show up as memory writes during a window in which the bench holds the channel still and expects no traffic.

// File: rtl/lli_dma_channel.sv
module lli_dma_channel #(
  parameter int          NPORTS     = 32,
  parameter logic [4:0]  MEM_PORT   = 5'd1,
  parameter logic [31:0] LAST_LINK  = 32'hFFFF_F800,
  parameter int          LONG_BURST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic [NPORTS-1:0] port_rdy,
  output logic              queue_done
);
  localparam int BLW = $clog2(LONG_BURST + 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_GATE, S_RD, S_WR, S_LINK} st_t;

  st_t             state;
  logic [2:0]      widx;
  logic [BLW-1:0]  bleft;
  logic            pause_q, inflight;
  logic [31:0]     lli, cfg, src, dst, cnt, para, nxt, dbuf;

  logic        busy, stop_wr, start_wr, fire, access, gate_ok, long_burst;
  logic [1:0]  swc, dwc, wmin, beat_code;
  logic [31:0] beat_bytes;

  assign busy     = state != S_IDLE;
  assign stop_wr  = reg_we && reg_addr == 5'h00 && !reg_wdata[0];
  assign start_wr = reg_we && reg_addr == 5'h00 &&  reg_wdata[0];

  assign swc  = (cfg[10:9]  == 2'd3) ? 2'd2 : cfg[10:9];
  assign dwc  = (cfg[26:25] == 2'd3) ? 2'd2 : cfg[26:25];
  assign wmin = (swc < dwc) ? swc : dwc;
  assign beat_code  = (cnt < (32'd1 << wmin)) ? 2'd0 : wmin;
  assign beat_bytes = 32'd1 << beat_code;
  assign long_burst = cfg[8:7] == 2'd2 || cfg[24:23] == 2'd2;

  assign gate_ok = (cfg[4:0]   == MEM_PORT || port_rdy[cfg[4:0]]) &&
                   (cfg[20:16] == MEM_PORT || port_rdy[cfg[20:16]]);

  assign access  = state == S_FETCH || state == S_RD || state == S_WR;
  assign mem_req = access && (inflight || !pause_q);
  assign fire    = mem_req && mem_gnt;

  assign mem_we    = state == S_WR;
  assign mem_size  = (state == S_FETCH) ? 2'd2 : beat_code;
  assign mem_wdata = dbuf;

  always_comb begin
    case (state)
      S_FETCH: mem_addr = lli + {27'd0, widx, 2'b00};
      S_WR:    mem_addr = dst;
      default: mem_addr = src;
    endcase
  end

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = {31'd0, busy};
      5'h04:   reg_rdata = {30'd0, pause_q, 1'b0};
      5'h08:   reg_rdata = lli;
      5'h0C:   reg_rdata = cfg;
      5'h10:   reg_rdata = src;
      5'h14:   reg_rdata = dst;
      5'h18:   reg_rdata = cnt;
      5'h1C:   reg_rdata = para;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; widx <= '0; bleft <= '0;
      pause_q <= 1'b0; inflight <= 1'b0; queue_done <= 1'b0;
      lli <= '0; cfg <= '0; src <= '0; dst <= '0;
      cnt <= '0; para <= '0; nxt <= '0; dbuf <= '0;
    end else begin
      queue_done <= 1'b0;
      inflight   <= mem_req && !mem_gnt && !stop_wr;
      if (reg_we && reg_addr == 5'h04) pause_q <= reg_wdata[1];
      if (stop_wr) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            if (reg_we && reg_addr == 5'h08) lli <= reg_wdata;
            if (start_wr) begin
              widx  <= '0;
              state <= S_FETCH;
            end
          end
          S_FETCH: if (fire) begin
            case (widx)
              3'd0:    cfg  <= mem_rdata;
              3'd1:    src  <= mem_rdata;
              3'd2:    dst  <= mem_rdata;
              3'd3:    cnt  <= mem_rdata;
              3'd4:    para <= mem_rdata;
              default: nxt  <= mem_rdata;
            endcase
            if (widx == 3'd5) state <= S_LOAD;
            else widx <= widx + 3'd1;
          end
          S_LOAD: state <= (cnt == 32'd0) ? S_LINK : S_GATE;
          S_GATE: if (gate_ok && !pause_q) begin
            bleft <= long_burst ? BLW'(LONG_BURST) : BLW'(1);
            state <= S_RD;
          end
          S_RD: if (fire) begin
            dbuf  <= mem_rdata;
            state <= S_WR;
          end
          S_WR: if (fire) begin
            if (!cfg[5])  src <= src + beat_bytes;
            if (!cfg[21]) dst <= dst + beat_bytes;
            cnt <= cnt - beat_bytes;
            if (cnt == beat_bytes)   state <= S_LINK;
            else if (bleft == BLW'(1)) state <= S_GATE;
            else begin
              bleft <= bleft - BLW'(1);
              state <= S_RD;
            end
          end
          S_LINK: begin
            if (nxt == LAST_LINK) begin
              queue_done <= 1'b1;
              state      <= S_IDLE;
            end else begin
              lli   <= nxt;
              widx  <= '0;
              state <= S_FETCH;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lli_dma_channel_chk.sv
module lli_dma_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [1:0]  mem_size,
  input logic        mem_gnt,
  input logic        queue_done,
  input logic        pause_q,
  input logic        busy
);
  logic stop_wr, pause_wr;
  assign stop_wr  = reg_we && reg_addr == 5'h00 && !reg_wdata[0];
  assign pause_wr = reg_we && reg_addr == 5'h04;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !stop_wr |=> mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we)); // R13

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    queue_done |=> !queue_done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    queue_done |-> !busy); // R7

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_q && !mem_req && !pause_wr |=> !mem_req); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R12

  AST_BEAT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3); // R5
endmodule

bind lli_dma_channel lli_dma_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_gnt(mem_gnt),
  .queue_done(queue_done), .pause_q(pause_q), .busy(busy)
);

// File: tb/tb_lli_dma_channel.sv
module tb_lli_dma_channel;
  localparam logic [31:0] LAST = 32'hFFFF_F800;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, reg_we, mem_req, mem_we, mem_gnt, queue_done;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata, mem_rdata, port_rdy;
  logic [1:0]  mem_size;

  lli_dma_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .port_rdy(port_rdy), .queue_done(queue_done)
  );

  typedef struct packed { logic [31:0] a; logic [1:0] s; logic [31:0] d; } wr_t;
  wr_t expq[$];
  logic [7:0] mb [0:4095];
  int n_chk = 0, n_fail = 0, n_wr = 0, n_done = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  initial begin
    logic        pend;
    logic [31:0] paddr;
    pend = 0; paddr = 0; mem_gnt = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      if (queue_done) n_done++;
      if (mem_gnt) begin
        mem_gnt = 0; pend = 0;
      end else if (mem_req) begin
        if (!pend) begin
          pend = 1; paddr = mem_addr;
        end else begin
          chk("R13 address held", mem_addr, paddr);
          mem_gnt = 1;
          if (mem_we) begin
            for (int i = 0; i < (1 << mem_size); i++) mb[(mem_addr + i) & 12'hFFF] = mem_wdata[8*i +: 8];
            n_wr++;
            if (expq.size() == 0) begin
              n_chk++; n_fail++;
              $display("FAIL R3 unexpected write actual=%h expected=none", mem_addr);
            end else begin
              wr_t e;
              e = expq.pop_front();
              chk("R3 write address", mem_addr, e.a);
              chk("R5 write size", {30'd0, mem_size}, {30'd0, e.s});
              chk("R2 write data", mem_wdata & ((mem_size == 2) ? 32'hFFFF_FFFF : (mem_size == 1) ? 32'hFFFF : 32'hFF),
                  e.d);
            end
          end else begin
            mem_rdata = 0;
            for (int i = 0; i < (1 << mem_size); i++) mem_rdata[8*i +: 8] = mb[(mem_addr + i) & 12'hFFF];
          end
        end
      end else pend = 0;
    end
  end

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic chkreg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rreg(a, v);
    chk(tag, v, exp);
  endtask

  function automatic logic [31:0] mk_cfg(input int sp, input int sio, input int sb, input int sw,
                                         input int dp, input int dio, input int db, input int dw);
    logic [15:0] s, d;
    s = 16'(sp) | 16'(sio << 5) | 16'(sb << 7) | 16'(sw << 9);
    d = 16'(dp) | 16'(dio << 5) | 16'(db << 7) | 16'(dw << 9);
    return {d, s};
  endfunction

  task automatic put_desc(input int base, input logic [31:0] c, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] p, input logic [31:0] nx);
    logic [31:0] w [6];
    w[0] = c; w[1] = s; w[2] = d; w[3] = n; w[4] = p; w[5] = nx;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 4; i++) mb[base + 4*k + i] = w[k][8*i +: 8];
  endtask

  task automatic exp_xfer(input int s, input bit sio, input int d, input bit dio, input int w, input int len);
    int rem;
    rem = len;
    while (rem > 0) begin
      int c, n;
      wr_t e;
      c = (rem < (1 << w)) ? 0 : w;
      n = 1 << c;
      e.a = d; e.s = 2'(c); e.d = 0;
      for (int i = 0; i < n; i++) e.d[8*i +: 8] = mb[s + i];
      expq.push_back(e);
      if (!sio) s += n;
      if (!dio) d += n;
      rem -= n;
    end
  endtask

  task automatic wait_done(input string tag);
    int d0;
    d0 = n_done;
    for (int i = 0; i < 3000 && n_done == d0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk({tag, " one done pulse"}, n_done - d0, 1);
    chk({tag, " scoreboard drained"}, expq.size(), 0);
  endtask

  task automatic wait_writes(input int target);
    for (int i = 0; i < 2000 && n_wr < target; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c1;
    int w0, w1, d0;
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; port_rdy = 0;
    for (int i = 0; i < 4096; i++) mb[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int r = 0; r < 8; r++) chkreg("R1 register zero", 5'(4 * r), 0);
    chk("R1 no request", {31'd0, mem_req}, 0);
    chk("R1 done low", {31'd0, queue_done}, 0);

    // R2 R3 R5 R7 R8 R10: three-link chain with a zero-length middle link
    put_desc(32'h100, mk_cfg(1,0,0,2, 1,0,0,2), 32'h400, 32'h600, 16, 8, 32'h120);
    put_desc(32'h120, mk_cfg(1,0,0,2, 1,0,0,2), 32'h500, 32'h6C0, 0, 9, 32'h140);
    put_desc(32'h140, mk_cfg(1,0,0,0, 1,0,0,2), 32'h410, 32'h640, 3, 32'h55, LAST);
    exp_xfer(32'h400, 0, 32'h600, 0, 2, 16);
    exp_xfer(32'h410, 0, 32'h640, 0, 0, 3);
    wreg(5'h08, 32'h100);
    wreg(5'h00, 1);
    wait_done("R7 R8 chain");
    chkreg("R2 last config", 5'h0C, mk_cfg(1,0,0,0, 1,0,0,2));
    chkreg("R2 last parameter", 5'h1C, 32'h55);
    chkreg("R3 source end", 5'h10, 32'h413);
    chkreg("R3 destination end", 5'h14, 32'h643);
    chkreg("R10 count zero", 5'h18, 0);
    chkreg("R7 enable cleared", 5'h00, 0);
    chkreg("R7 last link address", 5'h08, 32'h140);

    // R6 tail beats, R4 fixed destination
    put_desc(32'h180, mk_cfg(1,0,0,2, 1,0,0,2), 32'h420, 32'h680, 6, 0, 32'h1A0);
    put_desc(32'h1A0, mk_cfg(1,0,0,2, 1,1,0,2), 32'h430, 32'h6F0, 8, 0, LAST);
    exp_xfer(32'h420, 0, 32'h680, 0, 2, 6);
    exp_xfer(32'h430, 0, 32'h6F0, 1, 2, 8);
    wreg(5'h08, 32'h180);
    wreg(5'h00, 1);
    wait_done("R6 R4 chain");
    chkreg("R4 fixed destination", 5'h14, 32'h6F0);
    chkreg("R3 source advanced", 5'h10, 32'h438);

    // R9 request gating and bursts of 8, R10 live count
    put_desc(32'h1C0, mk_cfg(5,0,2,0, 1,0,0,0), 32'h440, 32'h700, 12, 0, LAST);
    exp_xfer(32'h440, 0, 32'h700, 0, 0, 12);
    w0 = n_wr;
    wreg(5'h08, 32'h1C0);
    wreg(5'h00, 1);
    repeat (40) @(negedge clk);
    chk("R9 no traffic without ready", n_wr - w0, 0);
    port_rdy[5] = 1;
    wait_writes(w0 + 1);
    port_rdy[5] = 0;
    repeat (60) @(negedge clk);
    chk("R9 one burst of eight", n_wr - w0, 8);
    chkreg("R10 remaining count", 5'h18, 4);
    chkreg("R10 live source", 5'h10, 32'h448);
    port_rdy[5] = 1;
    wait_done("R9 gated chain");
    port_rdy[5] = 0;

    // R11 pause and resume
    put_desc(32'h200, mk_cfg(1,0,0,0, 1,0,0,0), 32'h480, 32'h740, 40, 0, LAST);
    exp_xfer(32'h480, 0, 32'h740, 0, 0, 40);
    w0 = n_wr;
    wreg(5'h08, 32'h200);
    wreg(5'h00, 1);
    wait_writes(w0 + 5);
    wreg(5'h04, 32'h2);
    repeat (4) @(negedge clk);
    w1 = n_wr;
    rreg(5'h18, c1);
    repeat (50) @(negedge clk);
    chk("R11 no writes while paused", n_wr, w1);
    chkreg("R11 count frozen", 5'h18, c1);
    chkreg("R11 pause readback", 5'h04, 32'h2);
    wreg(5'h04, 0);
    wait_done("R11 resumed chain");

    // R12 stop and idle-only descriptor address
    put_desc(32'h240, mk_cfg(6,0,0,0, 1,0,0,0), 32'h4C0, 32'h780, 4, 0, LAST);
    w0 = n_wr; d0 = n_done;
    wreg(5'h08, 32'h240);
    wreg(5'h00, 1);
    repeat (30) @(negedge clk);
    wreg(5'h08, 32'h3FC);
    chkreg("R12 address write ignored while busy", 5'h08, 32'h240);
    wreg(5'h00, 0);
    chkreg("R12 enable reads zero", 5'h00, 0);
    port_rdy[6] = 1;
    repeat (30) @(negedge clk);
    chk("R12 no writes after stop", n_wr - w0, 0);
    chk("R12 no done after stop", n_done - d0, 0);
    chk("R12 no request after stop", {31'd0, mem_req}, 0);
    port_rdy[6] = 0;
    put_desc(32'h260, mk_cfg(1,0,0,2, 1,0,0,2), 32'h4D0, 32'h7A0, 8, 0, LAST);
    exp_xfer(32'h4D0, 0, 32'h7A0, 0, 2, 8);
    wreg(5'h08, 32'h260);
    chkreg("R12 address write taken while idle", 5'h08, 32'h260);
    wreg(5'h00, 1);
    wait_done("R12 restart");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule